// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Divider

This block is a sequential integer divider meant to sit beside the execution pipeline of a small in-order processor. A single-cycle start pulse hands it a dividend, a divisor and a flag that selects signed or unsigned division. It then forms one quotient bit per clock with a restoring shift-subtract step. The quotient is written to the low result register and the remainder to the high result register, and a one-cycle done pulse marks the write.

The number of iterations depends on the size of the dividend. The magnitude of the dividend is placed in the smallest multiple of 8 bits that holds it, so a short dividend finishes sooner. One setup cycle comes before the iterations. In signed mode a sign-correction cycle follows them. A parameter selects a fixed-latency variant instead: it always runs the full width, and in signed mode it adds one cycle for each negative operand. The busy output lets the issuing pipeline hold back a dependent read of the result registers, and any new divide, until the unit is free.

Top module: `iterdiv`

## Requirements
- R1: In the default variant (FIXED_LAT=0), an unsigned divide keeps busy_o high for 9, 17, 25 or 33 cycles. The count is set by the smallest of 8, 16, 24 or 32 bits that holds the dividend; a zero dividend counts as 8 bits.
- R2: In the default variant, a signed divide takes one cycle more than the unsigned case for the same size class: 10, 18, 26 or 34 cycles. The size class is taken from the absolute value of the dividend, read as two's complement.
- R3: With FIXED_LAT=1, an unsigned divide takes 33 cycles. A signed divide takes 33 cycles plus one cycle for each operand whose bit 31 is set, which gives 33, 34 or 35.
- R4: A start pulse is accepted only while busy_o is low. busy_o rises in the cycle after the accepting clock edge and stays high for exactly the latency of that operation. A start pulse while busy_o is high has no effect on the running operation, on its latency or on its results.
- R5: done_o is high for exactly one cycle: the first cycle after busy_o falls. lo_o and hi_o change only at the edge that raises done_o, and they hold their values at all other times.
- R6: An unsigned divide with a nonzero divisor gives lo_o = floor(dividend/divisor) and hi_o = dividend mod divisor.
- R7: A signed divide with a nonzero divisor rounds the quotient toward zero, and the remainder takes the sign of the dividend. Dividing 0x80000000 by 0xFFFFFFFF gives lo_o = 0x80000000 and hi_o = 0.
- R8: A divisor of zero, signed or unsigned, gives lo_o = 0xFFFFFFFF and hi_o = the unmodified dividend. The latency follows the same rule as any other divide.
- R9: While reset is asserted, and after it is released, busy_o and done_o are 0 and lo_o and hi_o are 0 until the first divide completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while busy_o is low |
| signed_i | input | 1 | 1 selects two's-complement operands |
| dividend_i | input | WIDTH | Dividend, sampled with start_i |
| divisor_i | input | WIDTH | Divisor, sampled with start_i |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | One-cycle pulse, results just written |
| lo_o | output | WIDTH | Quotient register |
| hi_o | output | WIDTH | Remainder register |

## Verification
The checker assumes that start_i, signed_i and the operands have known values at every clock edge after reset. It also assumes that the operands of an accepted start are the ones that the completed result belongs to, and it captures them itself at the accepting edge. The stimulus changes inputs only on falling clock edges and always holds the operands with the start pulse. Some start pulses are placed deliberately while the unit is busy, so that the ignore rule is exercised without breaking the checker's capture assumption.

// File: rtl/iterdiv_pkg.sv
package iterdiv_pkg;

   // control phases of the divider
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_ITER  = 2'd2,
      PH_FIX   = 2'd3
   } div_phase_e;

   // width of the post-iteration wait counter (at most two cycles)
   localparam int unsigned FIX_W = 2;

endpackage

// File: rtl/iterdiv_prep.sv
module iterdiv_prep #(
   parameter int unsigned WIDTH     = 32,
   parameter int unsigned SLICE     = 8,
   parameter bit          FIXED_LAT = 1'b0,
   localparam int unsigned NCLS     = WIDTH / SLICE,
   localparam int unsigned CW       = $clog2(WIDTH + 1)
) (
   input  logic                            sgn_i,
   input  logic [WIDTH-1:0]                a_i,
   input  logic [WIDTH-1:0]                b_i,
   output logic [WIDTH-1:0]                mag_a_o,
   output logic [WIDTH-1:0]                mag_b_o,
   output logic                            neg_q_o,
   output logic                            neg_r_o,
   output logic                            zero_o,
   output logic [CW-1:0]                   steps_o,
   output logic [iterdiv_pkg::FIX_W-1:0]   fix_o
);

   logic neg_a;
   logic neg_b;
   logic [NCLS-1:0] fits;
   logic [CW-1:0]   steps_early;

   assign neg_a   = sgn_i & a_i[WIDTH-1];
   assign neg_b   = sgn_i & b_i[WIDTH-1];
   assign mag_a_o = neg_a ? (~a_i + WIDTH'(1)) : a_i;
   assign mag_b_o = neg_b ? (~b_i + WIDTH'(1)) : b_i;
   assign neg_q_o = neg_a ^ neg_b;
   assign neg_r_o = neg_a;
   assign zero_o  = ~|b_i;

   // one flag per size class: magnitude holds in (c+1)*SLICE bits
   for (genvar c = 1; c < NCLS; c++) begin : g_fit
      assign fits[c-1] = ~|mag_a_o[WIDTH-1:c*SLICE];
   end
   assign fits[NCLS-1] = 1'b1;

   // smallest class wins: scan from the widest down
   always_comb begin
      steps_early = CW'(WIDTH);
      for (int c = NCLS - 1; c >= 0; c--) begin
         if (fits[c]) steps_early = CW'((c + 1) * SLICE);
      end
   end

   if (FIXED_LAT) begin : g_fixed
      assign steps_o = CW'(WIDTH);
      assign fix_o   = sgn_i ? ({1'b0, neg_a} + {1'b0, neg_b}) : '0;
   end else begin : g_early
      assign steps_o = steps_early;
      assign fix_o   = sgn_i ? iterdiv_pkg::FIX_W'(1) : '0;
   end

endmodule

// File: rtl/iterdiv_step.sv
module iterdiv_step #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] rem_i,
   input  logic [WIDTH-1:0] quo_i,
   input  logic [WIDTH-1:0] dvs_i,
   output logic [WIDTH-1:0] rem_o,
   output logic [WIDTH-1:0] quo_o
);

   logic [WIDTH:0] trial;
   logic [WIDTH:0] diff;
   logic           take;

   // bring the next dividend bit into the partial remainder
   assign trial = {rem_i, quo_i[WIDTH-1]};
   assign diff  = trial - {1'b0, dvs_i};
   assign take  = ~diff[WIDTH];

   assign rem_o = take ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
   assign quo_o = {quo_i[WIDTH-2:0], take};

endmodule

// File: rtl/iterdiv_post.sv
module iterdiv_post #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] quo_mag_i,
   input  logic [WIDTH-1:0] rem_mag_i,
   input  logic             neg_q_i,
   input  logic             neg_r_i,
   input  logic             zero_i,
   input  logic [WIDTH-1:0] dividend_i,
   output logic [WIDTH-1:0] lo_o,
   output logic [WIDTH-1:0] hi_o
);

   logic [WIDTH-1:0] quo_s;
   logic [WIDTH-1:0] rem_s;

   assign quo_s = neg_q_i ? (~quo_mag_i + WIDTH'(1)) : quo_mag_i;
   assign rem_s = neg_r_i ? (~rem_mag_i + WIDTH'(1)) : rem_mag_i;

   // a zero divisor yields a defined pattern instead of a trap
   assign lo_o = zero_i ? '1         : quo_s;
   assign hi_o = zero_i ? dividend_i : rem_s;

endmodule

// File: rtl/iterdiv.sv
module iterdiv #(
   parameter int unsigned WIDTH     = 32,
   parameter int unsigned SLICE     = 8,
   parameter bit          FIXED_LAT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             signed_i,
   input  logic [WIDTH-1:0] dividend_i,
   input  logic [WIDTH-1:0] divisor_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] lo_o,
   output logic [WIDTH-1:0] hi_o
);

   import iterdiv_pkg::*;

   localparam int unsigned CW = $clog2(WIDTH + 1);

   // elaboration-time parameter checks
   if (SLICE < 1 || WIDTH < 2 || (WIDTH % SLICE) != 0) begin : g_bad_cfg
      $error("iterdiv: WIDTH must be a multiple of SLICE and at least 2");
   end

   div_phase_e       phase_q;
   logic             sgn_q;
   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] b_q;
   logic [WIDTH-1:0] rem_q;
   logic [WIDTH-1:0] quo_q;
   logic [WIDTH-1:0] dvs_q;
   logic [CW-1:0]    cnt_q;
   logic [FIX_W-1:0] fix_q;
   logic             negq_q;
   logic             negr_q;
   logic             zero_q;
   logic             done_q;
   logic [WIDTH-1:0] lo_q;
   logic [WIDTH-1:0] hi_q;

   logic [WIDTH-1:0] mag_a;
   logic [WIDTH-1:0] mag_b;
   logic             neg_q;
   logic             neg_r;
   logic             zero_b;
   logic [CW-1:0]    steps;
   logic [FIX_W-1:0] fix;

   logic [WIDTH-1:0] step_rem;
   logic [WIDTH-1:0] step_quo;
   logic [WIDTH-1:0] post_qin;
   logic [WIDTH-1:0] post_rin;
   logic [WIDTH-1:0] res_lo;
   logic [WIDTH-1:0] res_hi;
   logic             accept;
   logic             last_iter;
   logic [CW-1:0]    pre_shift;

   iterdiv_prep #(
      .WIDTH     (WIDTH),
      .SLICE     (SLICE),
      .FIXED_LAT (FIXED_LAT)
   ) u_prep (
      .sgn_i   (sgn_q),
      .a_i     (a_q),
      .b_i     (b_q),
      .mag_a_o (mag_a),
      .mag_b_o (mag_b),
      .neg_q_o (neg_q),
      .neg_r_o (neg_r),
      .zero_o  (zero_b),
      .steps_o (steps),
      .fix_o   (fix)
   );

   iterdiv_step #(
      .WIDTH (WIDTH)
   ) u_step (
      .rem_i (rem_q),
      .quo_i (quo_q),
      .dvs_i (dvs_q),
      .rem_o (step_rem),
      .quo_o (step_quo)
   );

   // results come straight from the last step, or from the held registers
   assign post_qin = (phase_q == PH_ITER) ? step_quo : quo_q;
   assign post_rin = (phase_q == PH_ITER) ? step_rem : rem_q;

   iterdiv_post #(
      .WIDTH (WIDTH)
   ) u_post (
      .quo_mag_i  (post_qin),
      .rem_mag_i  (post_rin),
      .neg_q_i    (negq_q),
      .neg_r_i    (negr_q),
      .zero_i     (zero_q),
      .dividend_i (a_q),
      .lo_o       (res_lo),
      .hi_o       (res_hi)
   );

   assign accept    = start_i && (phase_q == PH_IDLE);
   assign last_iter = (cnt_q == CW'(1));
   assign pre_shift = CW'(WIDTH) - steps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sgn_q   <= 1'b0;
         a_q     <= '0;
         b_q     <= '0;
         rem_q   <= '0;
         quo_q   <= '0;
         dvs_q   <= '0;
         cnt_q   <= '0;
         fix_q   <= '0;
         negq_q  <= 1'b0;
         negr_q  <= 1'b0;
         zero_q  <= 1'b0;
         done_q  <= 1'b0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  sgn_q   <= signed_i;
                  a_q     <= dividend_i;
                  b_q     <= divisor_i;
                  phase_q <= PH_SETUP;
               end
            end
            PH_SETUP: begin
               rem_q   <= '0;
               quo_q   <= mag_a << pre_shift;
               dvs_q   <= mag_b;
               cnt_q   <= steps;
               fix_q   <= fix;
               negq_q  <= neg_q;
               negr_q  <= neg_r;
               zero_q  <= zero_b;
               phase_q <= PH_ITER;
            end
            PH_ITER: begin
               rem_q <= step_rem;
               quo_q <= step_quo;
               cnt_q <= cnt_q - CW'(1);
               if (last_iter) begin
                  if (fix_q == '0) begin
                     lo_q    <= res_lo;
                     hi_q    <= res_hi;
                     done_q  <= 1'b1;
                     phase_q <= PH_IDLE;
                  end else begin
                     phase_q <= PH_FIX;
                  end
               end
            end
            PH_FIX: begin
               fix_q <= fix_q - FIX_W'(1);
               if (fix_q == FIX_W'(1)) begin
                  lo_q    <= res_lo;
                  hi_q    <= res_hi;
                  done_q  <= 1'b1;
                  phase_q <= PH_IDLE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy_o = (phase_q != PH_IDLE);
   assign done_o = done_q;
   assign lo_o   = lo_q;
   assign hi_o   = hi_q;

endmodule

// File: rtl/iterdiv_checker.sv
module iterdiv_checker #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned SLICE = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             signed_i,
   input logic [WIDTH-1:0] dividend_i,
   input logic [WIDTH-1:0] divisor_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [WIDTH-1:0] lo_o,
   input logic [WIDTH-1:0] hi_o
);

   localparam int unsigned LW   = $clog2(WIDTH + 4) + 1;
   localparam int unsigned MAXL = WIDTH + 3;

   logic [LW-1:0]    lat_cnt;
   logic [WIDTH-1:0] cap_a;
   logic [WIDTH-1:0] cap_b;
   logic             cap_s;
   logic [2*WIDTH-1:0] recon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_cnt <= '0;
         cap_a   <= '0;
         cap_b   <= '0;
         cap_s   <= 1'b0;
      end else begin
         lat_cnt <= busy_o ? lat_cnt + LW'(1) : '0;
         if (start_i && !busy_o) begin
            cap_a <= dividend_i;
            cap_b <= divisor_i;
            cap_s <= signed_i;
         end
      end
   end

   assign recon = {{WIDTH{1'b0}}, lo_o} * {{WIDTH{1'b0}}, cap_b} + {{WIDTH{1'b0}}, hi_o};

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                          // R5
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));                       // R4
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(lo_o) && $stable(hi_o)));                // R5
   AST_MAX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (lat_cnt < LW'(MAXL)));                            // R1
   AST_MIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> ($past(lat_cnt) >= LW'(SLICE)));            // R1
   AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cap_b == '0) |-> (lo_o == '1 && hi_o == cap_a));   // R8
   AST_UNS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !cap_s && cap_b != '0)
         |-> (hi_o < cap_b && recon == {{WIDTH{1'b0}}, cap_a}));    // R6
   AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cap_s && cap_b != '0 && hi_o != '0)
         |-> (hi_o[WIDTH-1] == cap_a[WIDTH-1]));                    // R7

endmodule

bind iterdiv iterdiv_checker #(
   .WIDTH (WIDTH),
   .SLICE (SLICE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .signed_i   (signed_i),
   .dividend_i (dividend_i),
   .divisor_i  (divisor_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .lo_o       (lo_o),
   .hi_o       (hi_o)
);

// File: tb/iterdiv_test.sv
`timescale 1ns/1ps
module iterdiv_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        sgn = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;

   logic        busy0, busy1, done0, done1;
   logic [31:0] lo0, lo1, hi0, hi1;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #4 clk = ~clk;   // 125 MHz

   iterdiv #(.WIDTH(32), .SLICE(8), .FIXED_LAT(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sgn),
      .dividend_i(op_a), .divisor_i(op_b),
      .busy_o(busy0), .done_o(done0), .lo_o(lo0), .hi_o(hi0));

   iterdiv #(.WIDTH(32), .SLICE(8), .FIXED_LAT(1'b1)) uut_fix (
      .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sgn),
      .dividend_i(op_a), .divisor_i(op_b),
      .busy_o(busy1), .done_o(done1), .lo_o(lo1), .hi_o(hi1));

   // reference model state, index 0 = early variant, 1 = fixed variant
   int          m_left [2];
   bit          m_done [2];
   logic [31:0] m_lo [2];
   logic [31:0] m_hi [2];
   logic [31:0] p_lo [2];
   logic [31:0] p_hi [2];
   string       t_lat [2];
   string       t_res;

   function automatic int latency(input bit fixed, input logic [31:0] a,
                                  input logic [31:0] b, input bit s);
      logic [31:0] mag;
      int k;
      mag = (s && a[31]) ? -a : a;
      if (mag < 32'h100) k = 8;
      else if (mag < 32'h1_0000) k = 16;
      else if (mag < 32'h100_0000) k = 24;
      else k = 32;
      if (!fixed) return 1 + k + (s ? 1 : 0);
      return 33 + (s ? (int'(a[31]) + int'(b[31])) : 0);
   endfunction

   task automatic expect_result(input logic [31:0] a, input logic [31:0] b,
                                input bit s, output logic [31:0] q,
                                output logic [31:0] r);
      longint sa, sb;
      if (b == 0) begin
         q = 32'hFFFF_FFFF;
         r = a;
      end else if (!s) begin
         q = a / b;
         r = a % b;
      end else begin
         sa = longint'(signed'(a));
         sb = longint'(signed'(b));
         q = 32'(sa / sb);
         r = 32'(sa % sb);
      end
   endtask

   always @(posedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 2; i++) begin
            int old;
            old = m_left[i];
            m_done[i] = (old == 1);
            if (m_done[i]) begin
               m_lo[i] = p_lo[i];
               m_hi[i] = p_hi[i];
            end
            if (old > 0) m_left[i] = old - 1;
            if (start && old == 0) begin
               m_left[i] = latency(i == 1, op_a, op_b, sgn);
               expect_result(op_a, op_b, sgn, p_lo[i], p_hi[i]);
               if (i == 1) t_lat[i] = "R3";
               else t_lat[i] = sgn ? "R2" : "R1";
               t_res = (op_b == 0) ? "R8" : (sgn ? "R7" : "R6");
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy0 == (m_left[0] > 0), {t_lat[0], "/R4"}, "busy early", 32'(busy0), 32'(m_left[0] > 0));
         chk(busy1 == (m_left[1] > 0), {t_lat[1], "/R4"}, "busy fixed", 32'(busy1), 32'(m_left[1] > 0));
         chk(done0 == m_done[0], "R5", "done early", 32'(done0), 32'(m_done[0]));
         chk(done1 == m_done[1], "R5", "done fixed", 32'(done1), 32'(m_done[1]));
         chk(lo0 == m_lo[0], {t_res, "/R5"}, "lo early", lo0, m_lo[0]);
         chk(hi0 == m_hi[0], {t_res, "/R5"}, "hi early", hi0, m_hi[0]);
         chk(lo1 == m_lo[1], {t_res, "/R5"}, "lo fixed", lo1, m_lo[1]);
         chk(hi1 == m_hi[1], {t_res, "/R5"}, "hi fixed", hi1, m_hi[1]);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic issue(input logic [31:0] a, input logic [31:0] b, input bit s);
      @(negedge clk);
      op_a  = a;
      op_b  = b;
      sgn   = s;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk);
      while (m_left[0] != 0 || m_left[1] != 0 || m_done[0] || m_done[1]);
   endtask

   task automatic run(input logic [31:0] a, input logic [31:0] b, input bit s);
      issue(a, b, s);
      wait_idle();
   endtask

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_left[i] = 0; m_done[i] = 0; m_lo[i] = '0; m_hi[i] = '0;
         p_lo[i] = '0; p_hi[i] = '0; t_lat[i] = "R4";
      end
      t_res = "R9";
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(!busy0 && !busy1, "R9", "busy in reset", 32'({busy0, busy1}), 0);
      chk(!done0 && !done1, "R9", "done in reset", 32'({done0, done1}), 0);
      chk(lo0 == 0 && hi0 == 0 && lo1 == 0 && hi1 == 0, "R9", "results in reset", lo0 | hi0 | lo1 | hi1, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 / R3 / R6: unsigned size classes
      run(32'd200, 32'd7, 1'b0);
      run(32'h0000_1234, 32'h11, 1'b0);
      run(32'h00AB_CDEF, 32'h123, 1'b0);
      run(32'hFFFF_FFFF, 32'd3, 1'b0);
      run(32'd0, 32'd5, 1'b0);
      run(32'h0000_00FF, 32'hFFFF_FFFF, 1'b0);
      // R8: divide by zero
      run(32'd100, 32'd0, 1'b0);
      run(32'hFFFF_FFFB, 32'd0, 1'b1);
      // R2 / R3 / R7: signed cases
      run(-32'sd100, 32'd7, 1'b1);
      run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
      run(32'h7FFF_FFFF, -32'sd2, 1'b1);
      run(32'd70000, -32'sd3, 1'b1);
      run(-32'sd300, -32'sd4, 1'b1);
      run(32'd45, 32'd6, 1'b1);
      // R4: start while busy is ignored
      issue(32'd1000, 32'd3, 1'b0);
      repeat (3) @(negedge clk);
      op_a = 32'd9; op_b = 32'd9; sgn = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      // R4 / R5: back-to-back start in the done cycle of the early unit
      issue(32'd77, 32'd5, 1'b0);
      while (!m_done[0]) @(negedge clk);
      op_a = 32'h0001_0000; op_b = 32'd255; sgn = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      run(32'h0001_0000, 32'd255, 1'b0);

      repeat (3) @(negedge clk);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule